// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from many device slots onto four shared interrupt lines. Every slot has four request pins. Each pin is steered to one of the four lines by a rotation that depends on the slot number. For each line the block counts how many sources are currently asserted, and it drives the line high while that count is above zero.

The counts are not rebuilt from the inputs on every cycle. The block keeps the last level it saw on every pin. It adds +1 or -1 to the target line's count only when a pin changes. All changes that land on the same line in one cycle are summed before the count is updated.

One optional downstream stage is modelled as a group of secondary slots that sit behind a bridge. The bridge occupies one host slot. A secondary pin is rotated first by its own secondary slot number and then again by the bridge's host slot number. A parameter selects either the slot rotation or a plain pin-to-line identity mapping.

Top module: `irqagg_top`

## Requirements
- R1: Source index `slot*4 + pin` selects the bit of `host_irq` (host slots) or `sec_irq` (secondary slots). Each slot has exactly four pins, numbered 0 to 3.
- R2: A sampled level equal to the stored level of that pin leaves every count unchanged. While the inputs are held, the lines do not change.
- R3: A pin change adds +1 (rising) or -1 (falling) to the count of its mapped line. Changes on several pins in one cycle are all summed, so no event is lost.
- R4: A line is high exactly when its count is nonzero. The line reflects inputs sampled at a clock edge right after that edge.
- R5: With `SWIZZLE_MODE`=0, a host pin drives line `(slot + pin) mod 4`. With `SWIZZLE_MODE`=1, it drives line `pin`.
- R6: A secondary pin is first mapped to bridge pin `b = (sslot + pin) mod 4`, and then to host line `(BRIDGE_SLOT + b) mod 4`.
- R7: A line shared by several asserted sources stays high until the last of those sources deasserts.
- R8: A synchronous reset clears all stored levels and counts, and all lines are low after it. A pin that is high when reset is released counts as a fresh rising change on the next edge.
- R9: No count ever exceeds the total number of sources, even with every pin asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_irq | input | NUM_SLOTS*4 | Levels of the host-slot request pins, bit slot*4+pin |
| sec_irq | input | NUM_SEC_SLOTS*4 | Levels of the request pins of the slots behind the bridge |
| irq_line | output | 4 | Shared interrupt lines, high while their count is nonzero |

## Verification
The hardest case to reach is a burst of opposite changes landing on the same line in one cycle. In that burst, rises from some slots coincide with falls from others, and sources on both sides of the bridge are involved, so the net delta differs from either count alone. A single-pin walk cannot produce it. The stimulus therefore sets every pin, clears every pin, and then applies long runs of fully random input vectors in which many pins toggle at once. A behavioural model recounts the asserted sources per line from the mapping formulas on every clock, so any lost or double-counted event shows up as a line that stays high or drops early.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int PINS  = 4;
   localparam int LINES = 4;

   // Pin-to-line steering for one bus level.
   function automatic logic [1:0] swz(input int slot, input int pin, input int mode);
      if (mode == 1) return 2'(pin);
      return 2'((slot + pin) % LINES);
   endfunction
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] lvl_in,
   output logic [N-1:0] lvl_q,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl_in;
   end

   assign rise = lvl_in & ~lvl_q;
   assign fall = ~lvl_in & lvl_q;
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
   import irqagg_pkg::*;
#(
   parameter int N_HOST      = 32,
   parameter int N_SEC       = 16,
   parameter int BRIDGE_SLOT = 0,
   parameter int MODE        = 0,
   parameter int CW          = 6
) (
   input  logic [N_HOST+N_SEC-1:0] rise,
   input  logic [N_HOST+N_SEC-1:0] fall,
   output logic [LINES*CW-1:0]     up_o,
   output logic [LINES*CW-1:0]     dn_o
);
   logic [CW-1:0] up_a [LINES];
   logic [CW-1:0] dn_a [LINES];

   always_comb begin
      for (int l = 0; l < LINES; l++) begin
         up_a[l] = '0;
         dn_a[l] = '0;
      end
      for (int i = 0; i < N_HOST; i++) begin
         up_a[swz(i / PINS, i % PINS, MODE)] = up_a[swz(i / PINS, i % PINS, MODE)] + CW'(rise[i]);
         dn_a[swz(i / PINS, i % PINS, MODE)] = dn_a[swz(i / PINS, i % PINS, MODE)] + CW'(fall[i]);
      end
      for (int j = 0; j < N_SEC; j++) begin
         up_a[swz(BRIDGE_SLOT, int'(swz(j / PINS, j % PINS, MODE)), MODE)] =
            up_a[swz(BRIDGE_SLOT, int'(swz(j / PINS, j % PINS, MODE)), MODE)] + CW'(rise[N_HOST+j]);
         dn_a[swz(BRIDGE_SLOT, int'(swz(j / PINS, j % PINS, MODE)), MODE)] =
            dn_a[swz(BRIDGE_SLOT, int'(swz(j / PINS, j % PINS, MODE)), MODE)] + CW'(fall[N_HOST+j]);
      end
   end

   for (genvar g = 0; g < LINES; g++) begin : g_pack
      assign up_o[g*CW +: CW] = up_a[g];
      assign dn_o[g*CW +: CW] = dn_a[g];
   end
endmodule

// File: rtl/irqagg_count.sv
module irqagg_count #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] up,
   input  logic [CW-1:0] dn,
   output logic [CW-1:0] cnt,
   output logic          active
);
   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + up - dn;
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int NUM_SLOTS     = 8,
   parameter int NUM_SEC_SLOTS = 4,
   parameter int BRIDGE_SLOT   = 3,
   parameter int SWIZZLE_MODE  = 0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_SLOTS*4-1:0]     host_irq,
   input  logic [NUM_SEC_SLOTS*4-1:0] sec_irq,
   output logic [3:0]                 irq_line
);
   localparam int N_HOST = NUM_SLOTS * PINS;
   localparam int N_SEC  = NUM_SEC_SLOTS * PINS;
   localparam int NSRC   = N_HOST + N_SEC;
   localparam int CW     = $clog2(NSRC + 1);

   initial begin
      assert (NUM_SLOTS >= 1) else $fatal(1, "NUM_SLOTS must be at least 1");
      assert (NUM_SEC_SLOTS >= 1) else $fatal(1, "NUM_SEC_SLOTS must be at least 1");
      assert (BRIDGE_SLOT >= 0 && BRIDGE_SLOT < NUM_SLOTS) else $fatal(1, "BRIDGE_SLOT out of range");
      assert (SWIZZLE_MODE == 0 || SWIZZLE_MODE == 1) else $fatal(1, "SWIZZLE_MODE must be 0 or 1");
   end

   logic [NSRC-1:0]     lvl_flat;
   logic [NSRC-1:0]     rise, fall;
   logic [LINES*CW-1:0] up_flat, dn_flat;
   logic [LINES*CW-1:0] cnt_flat;

   irqagg_edge #(.N(NSRC)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_in ({sec_irq, host_irq}),
      .lvl_q  (lvl_flat),
      .rise   (rise),
      .fall   (fall)
   );

   irqagg_route #(
      .N_HOST      (N_HOST),
      .N_SEC       (N_SEC),
      .BRIDGE_SLOT (BRIDGE_SLOT),
      .MODE        (SWIZZLE_MODE),
      .CW          (CW)
   ) u_route (
      .rise (rise),
      .fall (fall),
      .up_o (up_flat),
      .dn_o (dn_flat)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_line
      irqagg_count #(.CW(CW)) u_cnt (
         .clk    (clk),
         .rst    (rst),
         .up     (up_flat[l*CW +: CW]),
         .dn     (dn_flat[l*CW +: CW]),
         .cnt    (cnt_flat[l*CW +: CW]),
         .active (irq_line[l])
      );
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
   parameter int NSRC  = 48,
   parameter int CW    = 6,
   parameter int NHW   = 32,
   parameter int NSW   = 16
) (
   input logic            clk,
   input logic            rst,
   input logic [NHW-1:0]  host_irq,
   input logic [NSW-1:0]  sec_irq,
   input logic [3:0]      irq_line,
   input logic [4*CW-1:0] cnt_flat,
   input logic [NSRC-1:0] lvl_flat
);
   int  cnt_sum;
   logic ovf;

   always_comb begin
      cnt_sum = 0;
      ovf = 1'b0;
      for (int l = 0; l < 4; l++) begin
         cnt_sum = cnt_sum + int'(cnt_flat[l*CW +: CW]);
         if (int'(cnt_flat[l*CW +: CW]) > NSRC) ovf = 1'b1;
      end
   end

   // R2: held inputs leave the counts untouched
   a_r2_hold_no_change: assert property (@(posedge clk) disable iff (rst)
      ($stable(host_irq) && $stable(sec_irq) && !$past(rst)) |=> $stable(cnt_flat));

   // R3: total of all counts equals the number of stored asserted pins
   a_r3_sum_conserved: assert property (@(posedge clk) disable iff (rst)
      cnt_sum == $countones(lvl_flat));

   // R9: no count exceeds the number of sources
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst) !ovf);

   // R8: reset leaves every line low
   a_r8_reset_clears: assert property (@(posedge clk) rst |=> (irq_line == 4'b0));

   // R4: a line can only rise after some input changed
   a_r4_rise_needs_change: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $stable(host_irq) && $stable(sec_irq)) |=> $stable(irq_line));
endmodule

bind irqagg_top irqagg_chk #(
   .NSRC (NSRC),
   .CW   (CW),
   .NHW  (N_HOST),
   .NSW  (N_SEC)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .host_irq (host_irq),
   .sec_irq  (sec_irq),
   .irq_line (irq_line),
   .cnt_flat (cnt_flat),
   .lvl_flat (lvl_flat)
);

// File: tb/tb_irqagg_top.sv
`timescale 1ns/1ps
module tb_irqagg_top;
   localparam int NS   = 8;
   localparam int NSS  = 4;
   localparam int BS   = 3;
   localparam int HW   = NS * 4;
   localparam int SW   = NSS * 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [HW-1:0] host_irq = '0;
   logic [SW-1:0] sec_irq = '0;
   logic [3:0]    irq_line;

   int    total = 0;
   int    bad = 0;
   int    cyc = 0;
   bit    done = 0;
   string tag = "R8";
   logic [3:0] exp_q = 4'b0;

   always #2.5 clk = ~clk;

   irqagg_top #(.NUM_SLOTS(NS), .NUM_SEC_SLOTS(NSS), .BRIDGE_SLOT(BS), .SWIZZLE_MODE(0)) dut (
      .clk      (clk),
      .rst      (rst),
      .host_irq (host_irq),
      .sec_irq  (sec_irq),
      .irq_line (irq_line)
   );

   // Reference: count asserted sources per line from the mapping formulas (R5, R6, R4)
   function automatic logic [3:0] ref_lines(input logic [HW-1:0] h, input logic [SW-1:0] s);
      int n [4];
      logic [3:0] r;
      for (int l = 0; l < 4; l++) n[l] = 0;
      for (int i = 0; i < HW; i++)
         if (h[i]) n[(i/4 + i%4) % 4]++;
      for (int j = 0; j < SW; j++)
         if (s[j]) n[(BS + (j/4 + j%4) % 4) % 4]++;
      for (int l = 0; l < 4; l++) r[l] = (n[l] != 0);
      return r;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      exp_q <= rst ? 4'b0 : ref_lines(host_irq, sec_irq);
   end

   // Compared on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         total++;
         if (irq_line !== exp_q) begin
            bad++;
            $display("FAIL %s cycle %0d irq_line actual=%b expected=%b", tag, cyc, irq_line, exp_q);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_lines(input string rq, input logic [3:0] e);
      total++;
      if (irq_line !== e) begin
         bad++;
         $display("FAIL %s directed irq_line actual=%b expected=%b", rq, irq_line, e);
      end
   endtask

   initial begin
      // R8: reset state
      tick(3);
      expect_lines("R8", 4'b0);
      rst = 1'b0;
      tick(1);

      // R1, R5: walk one host pin at a time
      tag = "R5";
      for (int i = 0; i < HW; i++) begin
         host_irq = '0;
         host_irq[i] = 1'b1;
         tick(1);
         expect_lines("R5", 4'b1 << ((i/4 + i%4) % 4));
      end
      host_irq = '0;
      tick(1);
      expect_lines("R5", 4'b0);

      // R6: walk one secondary pin at a time
      tag = "R6";
      for (int j = 0; j < SW; j++) begin
         sec_irq = '0;
         sec_irq[j] = 1'b1;
         tick(1);
         expect_lines("R6", 4'b1 << ((BS + (j/4 + j%4) % 4) % 4));
      end
      sec_irq = '0;
      tick(1);

      // R7: two sources on line 1 (slot0 pin1, slot1 pin0)
      tag = "R7";
      host_irq[1] = 1'b1;
      host_irq[4] = 1'b1;
      tick(1);
      expect_lines("R7", 4'b0010);
      host_irq[1] = 1'b0;
      tick(1);
      expect_lines("R7", 4'b0010);
      host_irq[4] = 1'b0;
      tick(1);
      expect_lines("R7", 4'b0000);

      // R2: hold a pattern and see no change
      tag = "R2";
      host_irq = 32'h0000_0011;
      tick(1);
      for (int k = 0; k < 5; k++) begin
         tick(1);
         expect_lines("R2", 4'b0011);
      end

      // R3, R9: everything at once, then everything off at once
      tag = "R9";
      host_irq = '1;
      sec_irq = '1;
      tick(1);
      expect_lines("R9", 4'b1111);
      tag = "R3";
      host_irq = '0;
      sec_irq = '0;
      tick(1);
      expect_lines("R3", 4'b0000);

      // R3: opposite changes on one line in one cycle (slot0 pin0 falls, slot1 pin3 rises: line 0)
      host_irq[0] = 1'b1;
      tick(1);
      host_irq[0] = 1'b0;
      host_irq[7] = 1'b1;
      tick(1);
      expect_lines("R3", 4'b0001);
      host_irq[7] = 1'b0;
      tick(1);
      expect_lines("R3", 4'b0000);

      // R8: reset with inputs held high, then release
      tag = "R8";
      host_irq = 32'h0000_000F;
      tick(1);
      rst = 1'b1;
      tick(2);
      expect_lines("R8", 4'b0000);
      rst = 1'b0;
      tick(1);
      expect_lines("R8", 4'b1111);
      host_irq = '0;
      tick(1);

      // R3, R4: random bursts with many simultaneous toggles
      tag = "R3";
      for (int k = 0; k < 3000; k++) begin
         host_irq = $urandom();
         sec_irq = SW'($urandom());
         tick(1);
      end
      host_irq = '0;
      sec_irq = '0;
      tick(2);
      expect_lines("R4", 4'b0000);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule